// File: doc/BRIEF.md
# Processor-to-Internal-Bus Request Bridge

This block sits between a host processor port and a simple internal request/response bus. It accepts read and write requests from the processor into a small in-order command queue. It turns each queued request into one master transaction on the internal bus. An address compare decides the target of each transaction. Addresses below a parameterised limit belong to the memory-controller-backed DRAM region. All other addresses belong to register-style internal agents.

The memory controller and this bridge share one data bus. Before any read, the bridge raises a hold request to the controller and waits for its acknowledge. On a read from an internal agent, the response comes from the internal bus. On a read from DRAM, the response is taken directly from the DRAM data path and returned to the processor unchanged, with no error screening. The second copy of that data, which the controller also returns on the internal bus, is absorbed by a drain phase and thrown away. Writes are posted: they retire when the internal bus grants them. A write to an internal agent also waits until the memory controller no longer owns the data bus.

Top module: `cib_bridge`

## Requirements
- R1: The command queue holds 4 requests. `hst_ready` is low while 4 requests are pending. Requests reach the internal bus and retire strictly in arrival order.
- R2: A request whose address is below `DRAM_LIMIT` (default 0x8000) is issued with `ib_sel_mc`=1. Any other address is issued with `ib_sel_mc`=0.
- R3: A write with `ib_sel_mc`=0 does not assert `ib_req` while `mc_bus_own` is 1. A write with `ib_sel_mc`=1 is issued even while `mc_bus_own` is 1.
- R4: For every read, `mc_hold` is raised first. `ib_req` is not asserted for the read until `mc_hold_ack` has been seen high.
- R5: On a read from an internal agent, `rsp_valid` pulses for exactly one cycle, one cycle after `ib_rvalid`, and `rsp_data` equals the `ib_rdata` sampled with it.
- R6: On a read from DRAM, `rsp_valid` pulses one cycle after `dram_valid`, and `rsp_data` equals `dram_rdata` bit for bit, including all-ones data. The internal-bus copy never produces a response.
- R7: After the DRAM data of a read has been captured, `ib_drain` stays high until the internal-bus copy (`ib_rvalid`) arrives, and `mc_hold` stays high throughout. The request retires only once both have been seen.
- R8: `mc_hold` goes low for at least one cycle between two consecutive reads, so every read produces its own rising edge of `mc_hold`.
- R9: A write retires on the cycle where `ib_req` and `ib_gnt` are both high, with `ib_addr`/`ib_wdata` equal to the queued values. A write produces no response.
- R10: `ib_rvalid` and `dram_valid` pulses that arrive while no read is outstanding produce no `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hst_valid | input | 1 | Processor request valid |
| hst_ready | output | 1 | Queue can accept a request |
| hst_write | input | 1 | 1 = write, 0 = read |
| hst_addr | input | 16 | Request address |
| hst_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | One-cycle read response strobe |
| rsp_data | output | 32 | Read response data |
| mc_bus_own | input | 1 | Memory controller currently owns the data bus |
| mc_hold | output | 1 | Hold request to the memory controller |
| mc_hold_ack | input | 1 | Memory controller has released the data bus |
| ib_req | output | 1 | Internal bus transaction request |
| ib_gnt | input | 1 | Internal bus grant; accepts the request |
| ib_write | output | 1 | Transaction direction, 1 = write |
| ib_sel_mc | output | 1 | Target is the memory controller |
| ib_addr | output | 16 | Transaction address |
| ib_wdata | output | 32 | Transaction write data |
| ib_drain | output | 1 | Dummy cycle: waiting to discard the duplicate DRAM data |
| ib_rvalid | input | 1 | Internal bus read data valid |
| ib_rdata | input | 32 | Internal bus read data |
| dram_valid | input | 1 | Direct DRAM read data valid on the shared bus |
| dram_rdata | input | 32 | Direct DRAM read data |

## Verification
The properties assume a well-behaved environment. `mc_hold_ack` is high only while `mc_hold` is high. `ib_gnt` is given only to a pending `ib_req`. For a DRAM read, the direct data arrives before the internal-bus copy. The bench stays inside these limits by modelling the memory controller and the internal-bus target in one responder process. That process acknowledges a hold two cycles after it rises and drops the acknowledge together with the hold. It grants only requests it sees. It schedules read data with fixed delays counted from the grant, with the direct DRAM data always ahead of the copy. Stray data pulses are injected only while the bridge is idle.

// File: rtl/cib_pkg.sv
package cib_pkg;

    localparam int CIB_AW = 16;
    localparam int CIB_DW = 32;

    typedef logic [CIB_AW-1:0] addr_t;
    typedef logic [CIB_DW-1:0] data_t;

    typedef struct packed {
        logic  wr;
        addr_t addr;
        data_t wdata;
    } cmd_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HOLD = 2'd1,
        ST_REQ  = 2'd2,
        ST_DATA = 2'd3
    } seq_st_e;

    function automatic logic in_dram(addr_t a, addr_t limit);
        return a < limit;
    endfunction

endpackage

// File: rtl/cib_cmd_queue.sv
module cib_cmd_queue
    import cib_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic push,
    input  cmd_t push_cmd,
    input  logic pop,
    output cmd_t head,
    output logic empty,
    output logic full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    cmd_t          slots [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;

    function automatic logic [PW-1:0] bump(logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty = (count == '0);
    assign full  = (count == CW'(DEPTH));
    assign head  = slots[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push && !full) begin
                slots[wr_ptr] <= push_cmd;
                wr_ptr        <= bump(wr_ptr);
            end
            if (pop && !empty) begin
                rd_ptr <= bump(rd_ptr);
            end
            case ({push && !full, pop && !empty})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/cib_seq.sv
module cib_seq
    import cib_pkg::*;
#(
    parameter logic [CIB_AW-1:0] DRAM_LIMIT = 16'h8000
) (
    input  logic  clk,
    input  logic  rst,
    input  cmd_t  head,
    input  logic  have_cmd,
    output logic  pop,
    input  logic  mc_bus_own,
    output logic  mc_hold,
    input  logic  mc_hold_ack,
    output logic  ib_req,
    input  logic  ib_gnt,
    output logic  ib_write,
    output logic  ib_sel_mc,
    output addr_t ib_addr,
    output data_t ib_wdata,
    output logic  ib_drain,
    input  logic  ib_rvalid,
    input  data_t ib_rdata,
    input  logic  dram_valid,
    input  data_t dram_rdata,
    output logic  rsp_valid,
    output data_t rsp_data
);
    seq_st_e st, st_n;
    logic    got_dram, got_dram_n;
    logic    got_ib, got_ib_n;
    logic    fire;
    data_t   fire_dat;
    logic    tgt_mc;

    assign tgt_mc    = in_dram(head.addr, DRAM_LIMIT);
    assign ib_write  = head.wr;
    assign ib_sel_mc = tgt_mc;
    assign ib_addr   = head.addr;
    assign ib_wdata  = head.wdata;

    // reads keep the controller held from request through drain
    assign mc_hold  = (st == ST_HOLD) ||
                      (((st == ST_REQ) || (st == ST_DATA)) && !head.wr);
    assign ib_drain = (st == ST_DATA) && tgt_mc && got_dram && !got_ib;

    always_comb begin
        st_n       = st;
        pop        = 1'b0;
        fire       = 1'b0;
        fire_dat   = '0;
        ib_req     = 1'b0;
        got_dram_n = got_dram;
        got_ib_n   = got_ib;
        case (st)
            ST_IDLE: begin
                got_dram_n = 1'b0;
                got_ib_n   = 1'b0;
                if (have_cmd) st_n = head.wr ? ST_REQ : ST_HOLD;
            end
            ST_HOLD: begin
                if (mc_hold_ack) st_n = ST_REQ;
            end
            ST_REQ: begin
                ib_req = (head.wr && !tgt_mc) ? !mc_bus_own : 1'b1;
                if (ib_req && ib_gnt) begin
                    if (head.wr) begin
                        pop  = 1'b1;
                        st_n = ST_IDLE;
                    end else begin
                        st_n = ST_DATA;
                    end
                end
            end
            ST_DATA: begin
                if (!tgt_mc) begin
                    if (ib_rvalid) begin
                        fire     = 1'b1;
                        fire_dat = ib_rdata;
                        pop      = 1'b1;
                        st_n     = ST_IDLE;
                    end
                end else begin
                    if (dram_valid && !got_dram) begin
                        fire       = 1'b1;
                        fire_dat   = dram_rdata;
                        got_dram_n = 1'b1;
                    end
                    if (ib_rvalid) got_ib_n = 1'b1;
                    if (got_dram_n && got_ib_n) begin
                        pop  = 1'b1;
                        st_n = ST_IDLE;
                    end
                end
            end
            default: st_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            got_dram  <= 1'b0;
            got_ib    <= 1'b0;
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            st        <= st_n;
            got_dram  <= got_dram_n;
            got_ib    <= got_ib_n;
            rsp_valid <= fire;
            if (fire) rsp_data <= fire_dat;
        end
    end
endmodule

// File: rtl/cib_bridge.sv
module cib_bridge
    import cib_pkg::*;
#(
    parameter int                DEPTH      = 4,
    parameter logic [CIB_AW-1:0] DRAM_LIMIT = 16'h8000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hst_valid,
    output logic              hst_ready,
    input  logic              hst_write,
    input  logic [CIB_AW-1:0] hst_addr,
    input  logic [CIB_DW-1:0] hst_wdata,
    output logic              rsp_valid,
    output logic [CIB_DW-1:0] rsp_data,
    input  logic              mc_bus_own,
    output logic              mc_hold,
    input  logic              mc_hold_ack,
    output logic              ib_req,
    input  logic              ib_gnt,
    output logic              ib_write,
    output logic              ib_sel_mc,
    output logic [CIB_AW-1:0] ib_addr,
    output logic [CIB_DW-1:0] ib_wdata,
    output logic              ib_drain,
    input  logic              ib_rvalid,
    input  logic [CIB_DW-1:0] ib_rdata,
    input  logic              dram_valid,
    input  logic [CIB_DW-1:0] dram_rdata
);
    cmd_t in_cmd, head;
    logic q_empty, q_full, pop;

    assign in_cmd    = '{wr: hst_write, addr: hst_addr, wdata: hst_wdata};
    assign hst_ready = !q_full;

    cib_cmd_queue #(.DEPTH(DEPTH)) u_queue (
        .clk      (clk),
        .rst      (rst),
        .push     (hst_valid),
        .push_cmd (in_cmd),
        .pop      (pop),
        .head     (head),
        .empty    (q_empty),
        .full     (q_full)
    );

    cib_seq #(.DRAM_LIMIT(DRAM_LIMIT)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .head        (head),
        .have_cmd    (!q_empty),
        .pop         (pop),
        .mc_bus_own  (mc_bus_own),
        .mc_hold     (mc_hold),
        .mc_hold_ack (mc_hold_ack),
        .ib_req      (ib_req),
        .ib_gnt      (ib_gnt),
        .ib_write    (ib_write),
        .ib_sel_mc   (ib_sel_mc),
        .ib_addr     (ib_addr),
        .ib_wdata    (ib_wdata),
        .ib_drain    (ib_drain),
        .ib_rvalid   (ib_rvalid),
        .ib_rdata    (ib_rdata),
        .dram_valid  (dram_valid),
        .dram_rdata  (dram_rdata),
        .rsp_valid   (rsp_valid),
        .rsp_data    (rsp_data)
    );
endmodule

// File: rtl/cib_bridge_chk.sv
module cib_bridge_chk
    import cib_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        mc_bus_own,
    input logic        mc_hold,
    input logic        mc_hold_ack,
    input logic        ib_req,
    input logic        ib_gnt,
    input logic        ib_write,
    input logic        ib_sel_mc,
    input addr_t       ib_addr,
    input logic        ib_drain,
    input logic        rsp_valid
);
    // R3: agent writes never requested while the controller owns the bus
    a_r3_agent_wr_clear: assert property (@(posedge clk) disable iff (rst)
        ib_req && ib_write && !ib_sel_mc |-> !mc_bus_own);

    // R4: a read request only under an acknowledged hold
    a_r4_rd_after_ack: assert property (@(posedge clk) disable iff (rst)
        ib_req && !ib_write |-> mc_hold && mc_hold_ack);

    // R7: drain cycles happen only while the controller is held
    a_r7_drain_under_hold: assert property (@(posedge clk) disable iff (rst)
        ib_drain |-> mc_hold);

    // R9: an ungranted request (not subject to ownership gating) is held stable
    a_r9_req_held: assert property (@(posedge clk) disable iff (rst)
        ib_req && !ib_gnt && !(ib_write && !ib_sel_mc) |=> ib_req && $stable(ib_addr));

    // R5: response strobe lasts a single cycle
    a_r5_rsp_single: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    // R10: no response unless a read held the controller one cycle earlier
    a_r10_no_rsp_idle: assert property (@(posedge clk) disable iff (rst)
        !mc_hold |=> !rsp_valid);
endmodule

bind cib_bridge cib_bridge_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .mc_bus_own  (mc_bus_own),
    .mc_hold     (mc_hold),
    .mc_hold_ack (mc_hold_ack),
    .ib_req      (ib_req),
    .ib_gnt      (ib_gnt),
    .ib_write    (ib_write),
    .ib_sel_mc   (ib_sel_mc),
    .ib_addr     (ib_addr),
    .ib_drain    (ib_drain),
    .rsp_valid   (rsp_valid)
);

// File: tb/test_cib_bridge.sv
module test_cib_bridge;
    localparam logic [15:0] LIMIT = 16'h8000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hst_valid = 1'b0, hst_write = 1'b0;
    logic [15:0] hst_addr = '0;
    logic [31:0] hst_wdata = '0;
    logic        hst_ready, rsp_valid;
    logic [31:0] rsp_data;
    logic        mc_bus_own = 1'b0;
    logic        mc_hold;
    logic        mc_hold_ack = 1'b0;
    logic        ib_req;
    logic        ib_gnt = 1'b0;
    logic        ib_write, ib_sel_mc, ib_drain;
    logic [15:0] ib_addr;
    logic [31:0] ib_wdata;
    logic        ib_rvalid = 1'b0;
    logic [31:0] ib_rdata = '0;
    logic        dram_valid = 1'b0;
    logic [31:0] dram_rdata = '0;

    always #2 clk = ~clk;  // 250 MHz

    cib_bridge i_cib_bridge (
        .clk(clk), .rst(rst),
        .hst_valid(hst_valid), .hst_ready(hst_ready), .hst_write(hst_write),
        .hst_addr(hst_addr), .hst_wdata(hst_wdata),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .mc_bus_own(mc_bus_own), .mc_hold(mc_hold), .mc_hold_ack(mc_hold_ack),
        .ib_req(ib_req), .ib_gnt(ib_gnt), .ib_write(ib_write), .ib_sel_mc(ib_sel_mc),
        .ib_addr(ib_addr), .ib_wdata(ib_wdata), .ib_drain(ib_drain),
        .ib_rvalid(ib_rvalid), .ib_rdata(ib_rdata),
        .dram_valid(dram_valid), .dram_rdata(dram_rdata)
    );

    function automatic logic [31:0] agent_val(logic [15:0] a);
        return {a ^ 16'h5A5A, a};
    endfunction
    function automatic logic [31:0] dram_val(logic [15:0] a);
        return (a == 16'h0FF0) ? 32'hFFFF_FFFF : {~a, a};
    endfunction

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // expected items (driver side owns the write indices)
    logic [15:0] exp_rd_addr [64];
    logic [15:0] exp_wr_addr [64];
    logic [31:0] exp_wr_data [64];
    int          n_rd_push = 0, n_wr_push = 0;

    // main-process counters
    int m_chk = 0, m_bad = 0;
    logic gnt_en = 1'b1;
    logic poke = 1'b0;

    // responder (bus target + memory controller model)
    int r_chk = 0, r_bad = 0;
    int wr_seen = 0, rd_grants = 0, hold_rises = 0;
    int rv_t = 0, dv_t = 0, cp_t = 0, hcnt = 0, drain_cnt = 0;
    int drive_cyc = -100;
    logic        prev_hold = 1'b0;
    logic        s_wr, s_mc;
    logic [15:0] s_addr;
    logic [31:0] s_data;

    always @(negedge clk) begin
        ib_rvalid  <= 1'b0;
        dram_valid <= 1'b0;
        if (rst) begin
            hcnt = 0; prev_hold = 1'b0; ib_gnt <= 1'b0; mc_hold_ack <= 1'b0;
        end else begin
            if (mc_hold && !prev_hold) hold_rises++;
            prev_hold = mc_hold;
            if (mc_hold) begin hcnt++; mc_hold_ack <= (hcnt >= 2); end
            else begin hcnt = 0; mc_hold_ack <= 1'b0; end
            if (ib_drain) drain_cnt++;
            if (dv_t > 0) begin
                dv_t--;
                if (dv_t == 0) begin
                    dram_valid <= 1'b1; dram_rdata <= dram_val(s_addr); drive_cyc = cyc;
                end
            end
            if (cp_t > 0) begin
                cp_t--;
                if (cp_t == 0) begin
                    ib_rvalid <= 1'b1; ib_rdata <= 32'hDEAD_BEEF;
                    r_chk++;
                    if (drain_cnt != 2 || !mc_hold) begin
                        r_bad++;
                        $display("FAIL R7: drain cycles %0d hold %0b, expected 2 and 1", drain_cnt, mc_hold);
                    end
                end
            end
            if (rv_t > 0) begin
                rv_t--;
                if (rv_t == 0) begin
                    ib_rvalid <= 1'b1; ib_rdata <= agent_val(s_addr); drive_cyc = cyc;
                end
            end
            if (poke) begin
                ib_rvalid <= 1'b1; ib_rdata <= 32'h1234_5678;
                dram_valid <= 1'b1; dram_rdata <= 32'h8765_4321;
            end
            if (ib_gnt) begin
                ib_gnt <= 1'b0;
                r_chk++;
                if (s_mc != (s_addr < LIMIT)) begin
                    r_bad++;
                    $display("FAIL R2: sel_mc %0b for addr %h, expected %0b", s_mc, s_addr, s_addr < LIMIT);
                end
                if (s_wr) begin
                    r_chk++;
                    if (wr_seen >= n_wr_push || s_addr != exp_wr_addr[wr_seen] ||
                        s_data != exp_wr_data[wr_seen]) begin
                        r_bad++;
                        $display("FAIL R9/R1: write %h/%h, expected %h/%h", s_addr, s_data,
                                 exp_wr_addr[wr_seen], exp_wr_data[wr_seen]);
                    end
                    r_chk++;
                    if (!s_mc && mc_bus_own) begin
                        r_bad++;
                        $display("FAIL R3: agent write granted with bus owned, got 1 expected 0");
                    end
                    wr_seen++;
                end else begin
                    rd_grants++;
                    if (s_mc) begin dv_t = 1; cp_t = 3; drain_cnt = 0; end
                    else rv_t = 2;
                end
            end else if (ib_req && gnt_en) begin
                s_wr = ib_write; s_mc = ib_sel_mc; s_addr = ib_addr; s_data = ib_wdata;
                if (!ib_write) begin
                    r_chk++;
                    if (!(mc_hold && mc_hold_ack)) begin
                        r_bad++;
                        $display("FAIL R4: read request with hold %0b ack %0b, expected 1 1", mc_hold, mc_hold_ack);
                    end
                end
                ib_gnt <= 1'b1;
            end
        end
    end

    // monitor: pops expected reads as responses appear
    int mo_chk = 0, mo_bad = 0, n_rd_pop = 0;
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            mo_chk++;
            if (n_rd_pop >= n_rd_push) begin
                mo_bad++;
                $display("FAIL R10/R6: unexpected response %h, expected none", rsp_data);
            end else begin
                automatic logic [15:0] a = exp_rd_addr[n_rd_pop];
                automatic logic [31:0] e = (a < LIMIT) ? dram_val(a) : agent_val(a);
                if (rsp_data !== e) begin
                    mo_bad++;
                    $display("FAIL %s: read %h data %h, expected %h", (a < LIMIT) ? "R6" : "R5", a, rsp_data, e);
                end
                mo_chk++;
                if (cyc != drive_cyc + 1) begin
                    mo_bad++;
                    $display("FAIL R5: response cycle %0d, expected %0d", cyc, drive_cyc + 1);
                end
                n_rd_pop++;
            end
        end
    end

    task automatic check(input bit ok, input string msg);
        m_chk++;
        if (!ok) begin m_bad++; $display("FAIL %s", msg); end
    endtask

    task automatic send(input logic wr, input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        if (wr) begin exp_wr_addr[n_wr_push] = a; exp_wr_data[n_wr_push] = d; n_wr_push++; end
        else begin exp_rd_addr[n_rd_push] = a; n_rd_push++; end
        hst_valid = 1'b1; hst_write = wr; hst_addr = a; hst_wdata = d;
        while (!hst_ready) @(negedge clk);
        @(negedge clk);
        hst_valid = 1'b0;
    endtask

    task automatic settle();
        int n = 0;
        while ((n_rd_pop < n_rd_push || wr_seen < n_wr_push) && n < 400) begin
            @(negedge clk); n++;
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic run();
        int g0, h0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(hst_ready && !mc_hold && !ib_req && !rsp_valid && !ib_drain,
              $sformatf("R1: reset outputs ready=%0b hold=%0b req=%0b rsp=%0b, expected 1 0 0 0",
                        hst_ready, mc_hold, ib_req, rsp_valid));
        // mixed traffic across both targets (R2, R5, R6, R9)
        send(1, 16'hA010, 32'h1111_0001);
        send(1, 16'h0040, 32'h2222_0002);
        send(0, 16'hA010, 0);
        send(0, 16'h0040, 0);
        send(0, 16'h0FF0, 0);
        send(1, 16'h7FFF, 32'h3333_0003);
        send(0, 16'h8000, 0);
        settle();
        check(n_rd_pop == n_rd_push, $sformatf("R6: %0d responses, expected %0d", n_rd_pop, n_rd_push));
        // R1: queue fill with no grants
        gnt_en = 1'b0;
        for (int i = 0; i < 4; i++) send(1, 16'hC000 + 16'(i), 32'hF000_0000 + i);
        @(negedge clk);
        check(!hst_ready, $sformatf("R1: ready %0b with 4 queued, expected 0", hst_ready));
        gnt_en = 1'b1;
        settle();
        check(wr_seen == n_wr_push, $sformatf("R1: %0d writes retired, expected %0d", wr_seen, n_wr_push));
        // R3: DRAM write proceeds while owned, agent write waits
        mc_bus_own = 1'b1;
        g0 = wr_seen;
        send(1, 16'h0100, 32'hAAAA_5555);
        repeat (6) @(negedge clk);
        check(wr_seen == g0 + 1, $sformatf("R3: DRAM writes retired %0d under ownership, expected 1", wr_seen - g0));
        send(1, 16'hB000, 32'h5555_AAAA);
        repeat (10) @(negedge clk);
        check(wr_seen == g0 + 1, $sformatf("R3: agent write retired %0d under ownership, expected 0", wr_seen - g0 - 1));
        mc_bus_own = 1'b0;
        settle();
        check(wr_seen == g0 + 2, $sformatf("R3: agent write retired %0d after release, expected 1", wr_seen - g0 - 1));
        // R10: stray pulses while idle
        g0 = n_rd_pop;
        poke = 1'b1; @(negedge clk); poke = 1'b0;
        repeat (5) @(negedge clk);
        check(n_rd_pop == g0, $sformatf("R10: responses after stray pulses %0d, expected 0", n_rd_pop - g0));
        // R8: back-to-back reads each get their own hold
        h0 = hold_rises;
        g0 = rd_grants;
        send(0, 16'h0200, 0);
        send(0, 16'h9000, 0);
        send(0, 16'h0300, 0);
        settle();
        check(hold_rises - h0 == 3, $sformatf("R8: hold rises %0d, expected 3", hold_rises - h0));
        check(rd_grants - g0 == 3, $sformatf("R4: read grants %0d, expected 3", rd_grants - g0));
        check(!mc_hold && !ib_drain, $sformatf("R7: idle hold %0b drain %0b, expected 0 0", mc_hold, ib_drain));
    endtask

    int wd_fail = 0;
    initial begin
        fork
            run();
            begin
                repeat (20000) @(posedge clk);
                wd_fail = 1;
            end
        join_any
        if (wd_fail != 0) $display("FAIL watchdog: run did not finish, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***",
                 m_chk + r_chk + mo_chk + wd_fail, m_bad + r_bad + mo_bad + wd_fail);
        $finish;
    end
endmodule